// File: doc/BRIEF.md
# Asynchronous SRAM Bus Emulator

This block lets a synchronous design stand in for a byte-wide asynchronous static RAM. An external master drives three active-low controls (select, write strobe and read gate), an address and write data. The block oversamples all of them with its fast system clock and keeps the stored bytes in an internal array. It returns read data on a separate output bus, together with a drive-enable flag that an external tri-state pad uses. It also reports a standby flag whenever the device is deselected.

Every control, address and data pin passes through a two-flop synchroniser. Edge detection on the synchronised select and write strobe finds the moment the select-and-strobe overlap ends, whichever of the two rises first. The write then stores the address and data sampled on the last clock that still saw the overlap. Output drive follows a three-signal truth table: drive happens only for select low, strobe high and read gate low. The read gate plays no part while a write is open.

The array depth is 2**ADDR_W words of DATA_W bits. A full-size part uses ADDR_W = 15 (32,768 bytes); the default is ADDR_W = 11 so that default elaboration stays small.

Top module: `sram_bus_emulator`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits; a byte written to an address is returned by a later read of that address, and other addresses keep their contents.
- R2: With select low, a write opens when the write strobe goes low and commits when the strobe rises while select is still low.
- R3: With the strobe low, a write opens when select goes low and commits when select rises, with the strobe still low.
- R4: While select and strobe are both low, the read gate level has no effect: the write commits with the gate high or low, and drive-enable stays 0.
- R5: drive-enable is 1 only for select=0, strobe=1, gate=0. It is 0 for each of the other seven level combinations of (select, strobe, gate).
- R6: standby is 1 whenever the synchronised select is 1, whatever the strobe and gate levels, and 0 while it is 0.
- R7: When select and strobe rise in the same clock sample, the write commits and drive-enable stays 0 on every cycle around the release.
- R8: Address and data that change in the same sample as the terminating rise are not used; the write stores the values held during the overlap.
- R9: Strobe pulses while select is high change no stored byte.
- R10: Latency: drive-enable and read data reflect the pins three clock edges after they settle; standby reflects select two edges after it settles.
- R11: During reset, drive-enable is 0 and standby is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_n | input | 1 | Active-low device select |
| bus_wstb_n | input | 1 | Active-low write strobe |
| bus_rgate_n | input | 1 | Active-low read output gate |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Data from the pad toward the array |
| bus_rdata | output | DATA_W | Data from the array toward the pad |
| bus_drive | output | 1 | Pad drive enable; 1 drives bus_rdata |
| standby | output | 1 | Device deselected / power-down indication |

## Verification
Each pin change reaches standby after two clock edges and reaches drive-enable and read data after three, because of the two synchroniser flops and the one output register. A committed write is visible to a read one edge after the terminating rise has been synchronised. The bench changes pins just after a falling clock edge and then waits four full clock periods before it samples at a falling edge. Every result has therefore settled a full cycle before it is checked. For the simultaneous-release case, the bench samples drive-enable on every cycle around the release, so a one-cycle glitch would show up.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    typedef struct packed {
        logic sel_n;
        logic wstb_n;
        logic rgate_n;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_IDLE = '{sel_n: 1'b1, wstb_n: 1'b1, rgate_n: 1'b1};

    function automatic logic ctl_reads(bus_ctl_t c);
        return !c.sel_n && c.wstb_n && !c.rgate_n;
    endfunction

    function automatic logic ctl_writes(bus_ctl_t c);
        return !c.sel_n && !c.wstb_n;
    endfunction

endpackage

// File: rtl/sram_emu_sync.sv
module sram_emu_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ctl_t          ctl_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] wdata_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              drive,
    output logic              standby
);

    typedef struct packed {
        logic              wr_open;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              drive;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        wr_now;
    logic        commit;

    always_comb begin
        wr_now          = ctl_writes(ctl_s);
        commit          = st_q.wr_open && !wr_now;
        st_d            = st_q;
        st_d.wr_open    = wr_now;
        st_d.addr       = addr_s;
        st_d.data       = wdata_s;
        st_d.drive      = ctl_reads(ctl_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en   = commit;
    assign wr_addr = st_q.addr;
    assign wr_data = st_q.data;
    assign drive   = st_q.drive;
    assign standby = ctl_s.sel_n;

    // R6
    standby_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !drive);

    // R4
    commit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !drive);

    // R2
    write_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ctl_s.sel_n || ctl_s.wstb_n) && $past(!ctl_s.sel_n && !ctl_s.wstb_n));

endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/sram_bus_emulator.sv
module sram_bus_emulator
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_wstb_n,
    input  logic              bus_rgate_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_drive,
    output logic              standby
);

    localparam int PAYLOAD_W = ADDR_W + DATA_W;

    bus_ctl_t          ctl_raw, ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] wdata_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    assign ctl_raw = '{sel_n: bus_sel_n, wstb_n: bus_wstb_n, rgate_n: bus_rgate_n};

    sram_emu_sync #(
        .WIDTH  ($bits(bus_ctl_t)),
        .STAGES (SYNC_STAGES),
        .RST_VAL(CTL_IDLE)
    ) u_ctl_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(ctl_raw),
        .sync_out(ctl_s)
    );

    sram_emu_sync #(
        .WIDTH  (PAYLOAD_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL('0)
    ) u_data_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({bus_addr, bus_wdata}),
        .sync_out({addr_s, wdata_s})
    );

    sram_emu_ctrl #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_s  (ctl_s),
        .addr_s (addr_s),
        .wdata_s(wdata_s),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .drive  (bus_drive),
        .standby(standby)
    );

    sram_emu_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(addr_s),
        .rd_data(bus_rdata)
    );

    generate
        if (SYNC_STAGES == 2) begin : g_pin_chk
            // R5
            drive_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(bus_drive) |-> $past(!bus_sel_n, 3) && $past(bus_wstb_n, 3)
                                     && $past(!bus_rgate_n, 3));
        end
    endgenerate

endmodule

// File: tb/sram_bus_emulator_tb.sv
module sram_bus_emulator_tb;

    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int SETTLE = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sel_n, wstb_n, rgate_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          drive, standby;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [DW-1:0] model [DEPTH];
    bit            known [DEPTH];

    always #5 clk = ~clk;

    sram_bus_emulator #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel_n(sel_n), .bus_wstb_n(wstb_n),
        .bus_rgate_n(rgate_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .bus_drive(drive), .standby(standby)
    );

    function automatic logic exp_drive(logic s, logic w, logic g);
        return !s && w && !g;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic settle(int n = SETTLE);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        sel_n = 1; wstb_n = 1; rgate_n = 1;
    endtask

    // strobe-ended write (R2), optional payload change at the release (R8)
    task automatic write_wstb(logic [AW-1:0] a, logic [DW-1:0] d, logic g, bit scramble);
        addr = a; wdata = d; rgate_n = g; wstb_n = 1; sel_n = 0; settle();
        wstb_n = 0; settle();
        check("R4", {31'd0, drive}, 32'd0);
        wstb_n = 1;
        if (scramble) begin addr = ~a; wdata = ~d; end
        settle();
        sel_n = 1; rgate_n = 1; settle();
        model[a] = d; known[a] = 1;
    endtask

    // select-ended write (R3)
    task automatic write_sel(logic [AW-1:0] a, logic [DW-1:0] d, logic g, bit scramble);
        addr = a; wdata = d; rgate_n = g; sel_n = 1; wstb_n = 0; settle();
        sel_n = 0; settle();
        check("R4", {31'd0, drive}, 32'd0);
        sel_n = 1;
        if (scramble) begin addr = ~a; wdata = ~d; end
        settle();
        wstb_n = 1; rgate_n = 1; settle();
        model[a] = d; known[a] = 1;
    endtask

    task automatic read_chk(string req, logic [AW-1:0] a);
        addr = a; wstb_n = 1; rgate_n = 0; sel_n = 0; settle();
        check(req, {31'd0, drive}, 32'd1);
        check(req, {24'd0, rdata}, {24'd0, model[a]});
        check("R6", {31'd0, standby}, 32'd0);
        idle(); settle();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) known[i] = 0;
        idle(); addr = '0; wdata = '0;
        rst_n = 0;
        settle(3);
        // R11
        check("R11", {31'd0, drive}, 32'd0);
        check("R11", {31'd0, standby}, 32'd1);
        rst_n = 1;
        settle();

        // R10 latency: select low with read set, drive due 3 edges later
        addr = 0; wstb_n = 1; rgate_n = 0;
        @(negedge clk); sel_n = 0;
        @(negedge clk); check("R10", {31'd0, standby}, 32'd1);
        @(negedge clk); check("R10", {31'd0, standby}, 32'd0);
        check("R10", {31'd0, drive}, 32'd0);
        @(negedge clk); check("R10", {31'd0, drive}, 32'd1);
        idle(); settle();

        // R2 / R3 directed, R4 gate both levels
        write_wstb(11'h000, 8'hA5, 1'b0, 0);
        write_wstb(11'h7FF, 8'h5A, 1'b1, 0);
        write_sel (11'h123, 8'h3C, 1'b0, 0);
        write_sel (11'h124, 8'hC3, 1'b1, 0);
        read_chk("R2", 11'h000);
        read_chk("R4", 11'h7FF);
        read_chk("R3", 11'h123);
        read_chk("R4", 11'h124);

        // R8: payload changes with the terminating rise
        write_wstb(11'h055, 8'h81, 1'b1, 1);
        write_sel (11'h066, 8'h18, 1'b1, 1);
        read_chk("R8", 11'h055);
        read_chk("R8", 11'h066);
        read_chk("R8", 11'h7AA);
        read_chk("R8", 11'h799);

        // R7: select and strobe rise together, gate low
        addr = 11'h200; wdata = 8'h77; rgate_n = 0; sel_n = 0; wstb_n = 0; settle();
        sel_n = 1; wstb_n = 1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check("R7", {31'd0, drive}, 32'd0);
        end
        idle(); model[11'h200] = 8'h77; known[11'h200] = 1;
        read_chk("R7", 11'h200);

        // R9: strobe pulses with select high leave the byte untouched
        addr = 11'h123; wdata = 8'hFF; sel_n = 1;
        for (int p = 0; p < 3; p++) begin
            wstb_n = 0; settle(); wstb_n = 1; settle();
        end
        read_chk("R9", 11'h123);

        // R5 / R6: all eight control combinations
        addr = 11'h005; wdata = 8'h3C;
        for (int k = 0; k < 8; k++) begin
            sel_n = k[2]; wstb_n = k[1]; rgate_n = k[0];
            settle();
            check("R5", {31'd0, drive}, {31'd0, exp_drive(k[2], k[1], k[0])});
            check("R6", {31'd0, standby}, {31'd0, k[2]});
            if (!k[2] && !k[1]) begin model[5] = 8'h3C; known[5] = 1; end
            idle(); settle();
        end
        read_chk("R5", 11'h005);

        // R1: random writes in both styles, then read back everything written
        for (int n = 0; n < 60; n++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = AW'($urandom);
            d = DW'($urandom);
            if ($urandom % 2) write_wstb(a, d, 1'($urandom), 1'($urandom));
            else              write_sel (a, d, 1'($urandom), 1'($urandom));
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (known[i]) read_chk("R1", AW'(i));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule